// File: doc/BRIEF.md
# Recency-Ordered Frame Replacement Tracker

This block follows which virtual pages sit in a small pool of physical frames and decides, for every page reference, whether it hits a resident page or faults. It keeps the resident page numbers in a stack ordered by recency of use. A referenced page is pulled out of its slot and pushed onto the top, so the least recently used page always sits in the bottom slot. When every frame is occupied, a fault evicts that bottom page.

A client presents a page number with a one-cycle strobe. One cycle later the block reports the result on registered outputs: whether the reference faulted, whether a victim was displaced and which page it was, and the frame index the referenced page now occupies. Until the pool is full, faults take free frames in ascending index order and report no victim. A page keeps its frame index for as long as it stays resident, even while its stack position moves. A build-time parameter switches the ordering to first-in-first-out for comparison. In that mode hits leave the order untouched, so the bottom entry is the page loaded longest ago.

Top module: `lru_tracker`

## Requirements
- R1: After reset all frames are empty. `outValid`, `fault` and `victimValid` read 0 until the first reference, and the first reference faults with no victim.
- R2: A reference strobed on `refValid` at a clock edge gives `outValid` = 1 for exactly the following cycle, with all result outputs registered.
- R3: A reference to a resident page gives `fault` = 0, `victimValid` = 0 and `frameIdx` equal to the frame that page occupies.
- R4: While fewer than NUM_FRAMES frames are occupied, a fault gives `victimValid` = 0. It fills frame indices 0, 1, 2, ... in the order the faults arrive.
- R5: In recency mode (USE_FIFO = 0), a fault with all frames occupied gives `victimValid` = 1. `victimPage` is the resident page whose most recent reference is oldest.
- R6: In recency mode, a hit moves the referenced page to the most-recent position, so it becomes the last candidate for eviction.
- R7: A page keeps its frame index while it stays resident. A page brought in by eviction takes the victim's frame index.
- R8: In FIFO mode (USE_FIFO = 1), hits do not change the order, and the victim is the resident page that was loaded earliest.
- R9: With three frames, the reference string 7,0,1,2,0,3,0,4,2,3,0,3,2,1,2,0,1,7,0,1 gives 12 faults in recency mode and 15 in FIFO mode.
- R10: A cycle with `refValid` = 0 produces `outValid` = 0 on the next cycle and leaves the resident set and its order unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; empties all frames |
| refValid | input | 1 | Strobe: a page reference is present this cycle |
| refPage | input | PAGE_W | Page number being referenced |
| outValid | output | 1 | Result of the previous cycle's reference is valid |
| fault | output | 1 | The reference missed the resident set |
| victimValid | output | 1 | A resident page was displaced by the reference |
| victimPage | output | PAGE_W | The displaced page number (meaningful when victimValid = 1) |
| frameIdx | output | FRAME_W | Frame index now holding the referenced page |

## Verification
On every cycle, the in-design assertions check several properties. The occupancy count never exceeds the frame count and grows by one only on a fill. A hit leaves the occupancy alone, and every push leaves the referenced page on top. A result follows each strobe and only a strobe, and a victim is never reported without a fault. Which page is displaced, and whether frame indices hold still across later reorderings, depends on whole reference histories. Only the bench's long sweeps show these, comparing both orderings side by side against a time-stamp model, along with the fault totals on the fixed reference string.

// File: rtl/lru_pkg.sv
package lru_pkg;

  // Strobes from control to the datapath, one set per reference cycle.
  typedef struct packed {
    logic take;   // a reference is being processed
    logic hit;    // the referenced page is resident
    logic fill;   // fault with a free frame available
    logic evict;  // fault with every frame occupied
    logic push;   // reorder the stack: remove one slot, push the page on top
  } ctrl_t;

endpackage

// File: rtl/lru_datapath.sv
module lru_datapath
  import lru_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 8,
  localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int CNT_W     = $clog2(NUM_FRAMES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PAGE_W-1:0]  refPage,
  input  ctrl_t              ctl,
  output logic               hit,
  output logic               full,
  output logic [PAGE_W-1:0]  victimPage,
  output logic [FRAME_W-1:0] frameIdx
);

  localparam int BOTTOM = NUM_FRAMES - 1;

  // Slot 0 is the most recent entry; slot BOTTOM is the replacement candidate.
  logic [PAGE_W-1:0]  stkPage  [NUM_FRAMES];
  logic [FRAME_W-1:0] stkFrame [NUM_FRAMES];
  logic [CNT_W-1:0]   count;

  logic [NUM_FRAMES-1:0] hitVec;
  logic [CNT_W-1:0]      hitPos;
  logic [CNT_W-1:0]      removePos;
  logic [FRAME_W-1:0]    newFrame;

  // Parallel compare of the reference against every occupied slot.
  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_match
    assign hitVec[i] = (CNT_W'(i) < count) && (stkPage[i] == refPage);
  end

  assign hit  = |hitVec;
  assign full = (count == CNT_W'(NUM_FRAMES));

  always_comb begin
    hitPos = '0;
    for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
      if (hitVec[i]) hitPos = CNT_W'(i);
    end
  end

  // Slot vacated by this reference: the first empty slot on a fill,
  // the bottom on an eviction, the matching slot on a hit.
  always_comb begin
    if (ctl.fill)       removePos = count;
    else if (ctl.evict) removePos = CNT_W'(BOTTOM);
    else                removePos = hitPos;
  end

  // Frame that holds the referenced page after this reference.
  always_comb begin
    if (ctl.fill)       newFrame = FRAME_W'(count);
    else if (ctl.evict) newFrame = stkFrame[BOTTOM];
    else                newFrame = stkFrame[hitPos[FRAME_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      for (int i = 0; i < NUM_FRAMES; i++) begin
        stkPage[i]  <= '0;
        stkFrame[i] <= '0;
      end
    end else begin
      if (ctl.push) begin
        for (int i = NUM_FRAMES - 1; i > 0; i--) begin
          if (CNT_W'(i) <= removePos) begin
            stkPage[i]  <= stkPage[i-1];
            stkFrame[i] <= stkFrame[i-1];
          end
        end
        stkPage[0]  <= refPage;
        stkFrame[0] <= newFrame;
      end
      if (ctl.fill) count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimPage <= '0;
      frameIdx   <= '0;
    end else if (ctl.take) begin
      victimPage <= ctl.evict ? stkPage[BOTTOM] : '0;
      frameIdx   <= newFrame;
    end
  end

  // R4: occupancy stays within the pool and grows only on a fill
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(NUM_FRAMES));
  p_fill_grows_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fill |=> count == CNT_W'($past(count) + 1'b1));
  // R3: a hit leaves the occupancy unchanged
  p_hit_keeps_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hit |=> $stable(count));
  // R6: after any push the referenced page is the most recent entry
  p_top_after_push_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.push |=> stkPage[0] == $past(refPage));
  // R10: an idle cycle leaves the stack alone
  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.take |=> ($stable(count) && stkPage[0] == $past(stkPage[0])));

endmodule

// File: rtl/lru_control.sv
module lru_control
  import lru_pkg::*;
#(
  parameter bit USE_FIFO = 1'b0
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  refValid,
  input  logic  hit,
  input  logic  full,
  output ctrl_t ctl,
  output logic  outValid,
  output logic  fault,
  output logic  victimValid
);

  always_comb begin
    ctl.take  = refValid;
    ctl.hit   = refValid && hit;
    ctl.fill  = refValid && !hit && !full;
    ctl.evict = refValid && !hit && full;
    // Recency ordering reorders on hits; FIFO ordering reorders only on loads.
    ctl.push  = ctl.fill || ctl.evict || (ctl.hit && !USE_FIFO);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      fault       <= 1'b0;
      victimValid <= 1'b0;
    end else begin
      outValid    <= refValid;
      fault       <= refValid && !hit;
      victimValid <= ctl.evict;
    end
  end

  // R2: a result follows every strobe one cycle later
  p_result_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> outValid);
  // R10: no strobe, no result
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !refValid |=> !outValid);
  // R5: a victim is only reported together with a fault
  p_victim_has_fault_r5: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> (fault && outValid));
  // R4: a free frame is never displaced
  p_no_victim_when_free_r4: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && !full) |=> !victimValid);

endmodule

// File: rtl/lru_tracker.sv
module lru_tracker
  import lru_pkg::*;
#(
  parameter int NUM_FRAMES = 4,
  parameter int PAGE_W     = 8,
  parameter bit USE_FIFO   = 1'b0,
  localparam int FRAME_W   = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refValid,
  input  logic [PAGE_W-1:0]  refPage,
  output logic               outValid,
  output logic               fault,
  output logic               victimValid,
  output logic [PAGE_W-1:0]  victimPage,
  output logic [FRAME_W-1:0] frameIdx
);

  ctrl_t ctl;
  logic  hit;
  logic  full;

  lru_control #(
    .USE_FIFO (USE_FIFO)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .refValid    (refValid),
    .hit         (hit),
    .full        (full),
    .ctl         (ctl),
    .outValid    (outValid),
    .fault       (fault),
    .victimValid (victimValid)
  );

  lru_datapath #(
    .NUM_FRAMES (NUM_FRAMES),
    .PAGE_W     (PAGE_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .refPage    (refPage),
    .ctl        (ctl),
    .hit        (hit),
    .full       (full),
    .victimPage (victimPage),
    .frameIdx   (frameIdx)
  );

endmodule

// File: tb/lru_tracker_tb.sv
module lru_tracker_tb;

  localparam int NF = 3;
  localparam int PW = 4;
  localparam int FW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refValid = 1'b0;
  logic [PW-1:0] refPage = '0;

  logic          oV   [2];
  logic          oF   [2];
  logic          oVV  [2];
  logic [PW-1:0] oVP  [2];
  logic [FW-1:0] oFr  [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model: per mode, frame-indexed residency with time stamps
  int mPage  [2][NF];
  bit mValid [2][NF];
  int mStamp [2][NF];
  int mCount [2];
  int tick;
  int faultTally [2];

  always #2.5 clk = ~clk;

  lru_tracker #(.NUM_FRAMES(NF), .PAGE_W(PW), .USE_FIFO(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refPage(refPage),
    .outValid(oV[0]), .fault(oF[0]), .victimValid(oVV[0]),
    .victimPage(oVP[0]), .frameIdx(oFr[0]));

  lru_tracker #(.NUM_FRAMES(NF), .PAGE_W(PW), .USE_FIFO(1'b1)) u_fifo (
    .clk(clk), .rstN(rstN), .refValid(refValid), .refPage(refPage),
    .outValid(oV[1]), .fault(oF[1]), .victimValid(oVV[1]),
    .victimPage(oVP[1]), .frameIdx(oFr[1]));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int m = 0; m < 2; m++) begin
      mCount[m] = 0;
      for (int f = 0; f < NF; f++) begin
        mValid[m][f] = 1'b0; mPage[m][f] = 0; mStamp[m][f] = 0;
      end
    end
    tick = 0;
  endtask

  // Stamp = last use (recency mode) or load time (FIFO mode).
  task automatic modelRef(int m, int pg, output bit eF, output bit eV,
                          output int eVP, output int eFr);
    int f;
    f = -1;
    eV = 1'b0; eVP = 0;
    for (int k = 0; k < NF; k++)
      if (mValid[m][k] && mPage[m][k] == pg) f = k;
    if (f >= 0) begin
      eF = 1'b0;
      if (m == 0) mStamp[m][f] = tick;
    end else begin
      eF = 1'b1;
      if (mCount[m] < NF) begin
        f = mCount[m];
        mCount[m]++;
      end else begin
        f = 0;
        for (int k = 1; k < NF; k++)
          if (mStamp[m][k] < mStamp[m][f]) f = k;
        eV = 1'b1;
        eVP = mPage[m][f];
      end
      mValid[m][f] = 1'b1;
      mPage[m][f] = pg;
      mStamp[m][f] = tick;
    end
    eFr = f;
  endtask

  // Called at a falling edge; returns at the falling edge after the result.
  task automatic doRef(int pg);
    bit eF [2]; bit eV [2]; int eVP [2]; int eFr [2];
    string tag;
    for (int m = 0; m < 2; m++) modelRef(m, pg, eF[m], eV[m], eVP[m], eFr[m]);
    tick++;
    refValid = 1'b1;
    refPage  = PW'(pg);
    @(negedge clk);
    refValid = 1'b0;
    for (int m = 0; m < 2; m++) begin
      if (!eF[m]) tag = "R3";
      else if (!eV[m]) tag = "R4";
      else tag = (m == 0) ? "R5" : "R8";
      if (eF[m]) faultTally[m]++;
      chk(oV[m] == 1'b1, "R2", "outValid", int'(oV[m]), 1);
      chk(oF[m] == eF[m], tag, "fault", int'(oF[m]), int'(eF[m]));
      chk(oVV[m] == eV[m], tag, "victimValid", int'(oVV[m]), int'(eV[m]));
      if (eV[m])
        chk(int'(oVP[m]) == eVP[m], (m == 0) ? "R5 R6" : "R8", "victimPage",
            int'(oVP[m]), eVP[m]);
      chk(int'(oFr[m]) == eFr[m], "R7", "frameIdx", int'(oFr[m]), eFr[m]);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      chk(oV[m] == 1'b0, "R10", "outValid when idle", int'(oV[m]), 0);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    refValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    for (int m = 0; m < 2; m++) begin
      chk(oV[m] == 1'b0, "R1", "outValid after reset", int'(oV[m]), 0);
      chk(oF[m] == 1'b0, "R1", "fault after reset", int'(oF[m]), 0);
      chk(oVV[m] == 1'b0, "R1", "victimValid after reset", int'(oVV[m]), 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int seq [20] = '{7,0,1,2,0,3,0,4,2,3,0,3,2,1,2,0,1,7,0,1};
    logic [7:0] lfsr;
    int pg;
    modelReset();

    // R1 R9: reference string under both orderings
    applyReset();
    faultTally[0] = 0; faultTally[1] = 0;
    foreach (seq[i]) doRef(seq[i]);
    chk(faultTally[0] == 12, "R9", "recency fault total", faultTally[0], 12);
    chk(faultTally[1] == 15, "R9", "FIFO fault total", faultTally[1], 15);

    // R10: idle cycles change nothing; next hits confirm residency
    idle(); idle();
    doRef(1); doRef(0); doRef(7);

    // R6 R8: repeated hits to the oldest page then a fault
    applyReset();
    doRef(1); doRef(2); doRef(3);
    doRef(1); doRef(1);
    doRef(4);
    doRef(2);

    // Near-exhaustive sweep: pseudo-random pages over small ranges,
    // mixing back-to-back references and idle gaps
    for (int pass = 0; pass < 4; pass++) begin
      applyReset();
      lfsr = 8'hA5 + 8'(pass);
      for (int n = 0; n < 400; n++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        pg = int'(lfsr[3:0]) % (4 + pass * 3);
        doRef(pg);
        if (lfsr[7:6] == 2'b11) idle();
      end
    end

    // Every page value at the edges of the page width
    applyReset();
    for (int p = 0; p < (1 << PW); p++) begin
      doRef(p);
      doRef((1 << PW) - 1 - p);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule